// File: doc/BRIEF.md
# Edge-Triggered Input Capture Unit

This block timestamps transitions on three external digital inputs. Each channel passes its asynchronous pin through a two-stage synchroniser. It compares the synchronised level with the level it saw one cycle earlier. When a transition matches the channel's configured edge, the channel stores the value of a free-running timer that the block receives from outside. It then holds a sticky capture flag, which can raise an interrupt request, until software clears it.

The last channel can also start an analog-to-digital conversion. On each qualifying edge it emits a start pulse exactly one clock wide, with its interrupt request raised in that same cycle. Software can therefore begin work when the conversion starts rather than when it ends. Because the pulse comes from an edge and not from a level, a pin held high for a long time starts only one conversion.

A write port configures the channels: one channel per write, selected by address. The timer, the converter and any bus decoding sit outside the block.

Top module: `capt_unit`

## Requirements
- R1: Each of the three channels watches its own pin through a two-flip-flop synchroniser. The stored timestamp is the timer value that the design samples at the third rising clock edge after the pin changes. With a timer that increments on every edge, this is the count read just after the change plus 2.
- R2: The edge select is write-data bits [1:0]: 00 = no capture, 01 = rising only, 10 = falling only, 11 = both edges. A transition that does not match the selection leaves the capture flag clear.
- R3: A write to channel address 0, 1 or 2 (cfg_addr) loads that channel's edge select, interrupt enable (bit 2) and conversion enable (bit 3). The write is accepted only when cfg_we is high.
- R4: The capture flag (cap_valid) is sticky. Writing 1 to bit 4 of a channel's write data clears both its capture flag and its overrun flag.
- R5: A qualifying edge that arrives while the capture flag is still set overwrites the timestamp with the new value and sets the channel's overrun flag (cap_ovr).
- R6: Each channel's interrupt output is high exactly when its capture flag and its interrupt enable are both set.
- R7: adc_soc is a one-cycle pulse, issued once per qualifying edge of channel 2 when that channel's conversion enable is set. A pin held high does not repeat the pulse. The conversion enable bit has no effect on channels 0 and 1.
- R8: In the cycle that adc_soc is high, channel 2's interrupt output is also high, provided its interrupt enable is set.
- R9: A write to address 3 changes no channel state.
- R10: After reset, all flags, interrupt outputs and adc_soc are low, and every channel has capture disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_cnt | input | 16 | Free-running timer count to be stamped |
| cap_pin | input | 3 | Asynchronous capture inputs, one per channel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Channel selected by a write |
| cfg_wdata | input | 5 | {clear, conv enable, irq enable, edge select[1:0]} |
| cap_stamp | output | 48 | Stored timestamps, channel n in bits [16n+15:16n] |
| cap_valid | output | 3 | Sticky capture flags |
| cap_ovr | output | 3 | Overrun flags |
| cap_irq | output | 3 | Interrupt requests |
| adc_soc | output | 1 | One-cycle conversion start strobe |

## Verification
The assertions assume that each synchronised pin stays at a level for at least two clock cycles between transitions. Without that, a both-edges channel could see a qualifying edge in two consecutive cycles, and the one-cycle width check on the conversion strobe would not hold. The bench keeps every pin level for at least five cycles, and it issues configuration writes only while the pins are quiet. A free-running timer in the bench advances on every clock edge, so a stamp taken one cycle off produces a different expected value.

// File: rtl/capt_pkg.sv
package capt_pkg;
    localparam int unsigned CFG_W = 5;
    localparam int unsigned BIT_IRQ = 2;
    localparam int unsigned BIT_SOC = 3;
    localparam int unsigned BIT_CLR = 4;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/capt_sync.sv
module capt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    generate
        if (STAGES == 1) begin : g_one
            assign chain_d = async_in;
        end else begin : g_many
            assign chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/capt_channel.sv
module capt_channel
    import capt_pkg::*;
#(
    parameter int unsigned TW      = 16,
    parameter bit          HAS_SOC = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_sync,
    input  logic [TW-1:0]    timer_cnt,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [TW-1:0]    stamp,
    output logic             valid,
    output logic             ovr,
    output logic             irq,
    output logic             soc
);
    typedef struct packed {
        edge_sel_e     sel;
        logic          irq_en;
        logic          soc_en;
        logic          valid;
        logic          ovr;
        logic          soc;
        logic          prev;
        logic [TW-1:0] ts;
    } chan_t;

    chan_t st_q, st_d;
    logic  rise, fall, hit, clr;

    always_comb begin
        rise = pin_sync & ~st_q.prev;
        fall = ~pin_sync & st_q.prev;
        hit  = (st_q.sel[0] & rise) | (st_q.sel[1] & fall);
        clr  = wr_en & wr_data[BIT_CLR];

        st_d      = st_q;
        st_d.prev = pin_sync;
        st_d.soc  = 1'b0;

        if (wr_en) begin
            st_d.sel    = edge_sel_e'(wr_data[1:0]);
            st_d.irq_en = wr_data[BIT_IRQ];
            st_d.soc_en = HAS_SOC ? wr_data[BIT_SOC] : 1'b0;
        end
        if (clr) begin
            st_d.valid = 1'b0;
            st_d.ovr   = 1'b0;
        end
        if (hit) begin
            st_d.ts    = timer_cnt;
            st_d.valid = 1'b1;
            st_d.soc   = st_q.soc_en;
            if (st_q.valid && !clr) st_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sel: EDGE_OFF, default: '0};
        else        st_q <= st_d;
    end

    assign stamp = st_q.ts;
    assign valid = st_q.valid;
    assign ovr   = st_q.ovr;
    assign irq   = st_q.valid & st_q.irq_en;
    assign soc   = st_q.soc;

    // R2: a channel with capture disabled never sets its flag
    a_r2_off_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sel == EDGE_OFF) |=> !$rose(st_q.valid));

    // R4/R5: a held flag with no new edge keeps its stamp
    a_r4_stamp_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && !hit) |=> $stable(st_q.ts));

    // R5: overrun only appears on a channel already holding a capture
    a_r5_ovr_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovr) |-> $past(st_q.valid));

    // R7: conversion strobe is a single cycle wide
    a_r7_soc_single: assert property (@(posedge clk) disable iff (!rst_n)
        soc |=> !soc);

    // R8: strobe and interrupt coincide
    a_r8_irq_with_soc: assert property (@(posedge clk) disable iff (!rst_n)
        (soc && st_q.irq_en) |-> irq);
endmodule

// File: rtl/capt_unit.sv
module capt_unit
    import capt_pkg::*;
#(
    parameter int unsigned NCH     = 3,
    parameter int unsigned TW      = 16,
    parameter int unsigned SYNC_N  = 2,
    parameter int unsigned SOC_CH  = 2,
    localparam int unsigned AW     = (NCH > 1) ? $clog2(NCH + 1) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     timer_cnt,
    input  logic [NCH-1:0]    cap_pin,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [NCH*TW-1:0] cap_stamp,
    output logic [NCH-1:0]    cap_valid,
    output logic [NCH-1:0]    cap_ovr,
    output logic [NCH-1:0]    cap_irq,
    output logic              adc_soc
);
    logic [NCH-1:0] pin_s;
    logic [NCH-1:0] wr_sel;
    logic [NCH-1:0] soc_vec;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign wr_sel[i] = cfg_we && (cfg_addr == AW'(i));

            capt_sync #(.STAGES(SYNC_N)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (cap_pin[i]),
                .sync_out (pin_s[i])
            );

            capt_channel #(.TW(TW), .HAS_SOC(i == SOC_CH)) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_sync  (pin_s[i]),
                .timer_cnt (timer_cnt),
                .wr_en     (wr_sel[i]),
                .wr_data   (cfg_wdata),
                .stamp     (cap_stamp[i*TW +: TW]),
                .valid     (cap_valid[i]),
                .ovr       (cap_ovr[i]),
                .irq       (cap_irq[i]),
                .soc       (soc_vec[i])
            );
        end
    endgenerate

    assign adc_soc = |soc_vec;

    // R3/R9: at most one channel is written per cycle
    a_r9_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R7: only the designated channel can drive the strobe
    a_r7_soc_source: assert property (@(posedge clk) disable iff (!rst_n)
        adc_soc |-> soc_vec[SOC_CH]);
endmodule

// File: tb/capt_unit_tb.sv
`timescale 1ns/1ps
module capt_unit_tb;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] tmr = '0;
    logic [2:0]    pins = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [4:0]    cfg_wdata = '0;
    logic [3*TW-1:0] cap_stamp;
    logic [2:0]    cap_valid, cap_ovr, cap_irq;
    logic          adc_soc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) tmr <= tmr + 1'b1;

    capt_unit u_dut (
        .clk(clk), .rst_n(rst_n), .timer_cnt(tmr), .cap_pin(pins),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cap_stamp(cap_stamp), .cap_valid(cap_valid), .cap_ovr(cap_ovr),
        .cap_irq(cap_irq), .adc_soc(adc_soc)
    );

    // vector: [7:6] channel, [5:4] edge select, [3] new pin level, [2] capture expected
    localparam logic [7:0] VEC [8] = '{
        {2'd0, 2'b01, 1'b1, 1'b1, 2'b00},
        {2'd0, 2'b01, 1'b0, 1'b0, 2'b00},
        {2'd1, 2'b10, 1'b1, 1'b0, 2'b00},
        {2'd1, 2'b10, 1'b0, 1'b1, 2'b00},
        {2'd2, 2'b11, 1'b1, 1'b1, 2'b00},
        {2'd2, 2'b11, 1'b0, 1'b1, 2'b00},
        {2'd0, 2'b00, 1'b1, 1'b0, 2'b00},
        {2'd1, 2'b11, 1'b1, 1'b1, 2'b00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [4:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(input int ch, input logic lvl, output logic [TW-1:0] exp_ts);
        @(negedge clk);
        exp_ts = tmr + 16'd2;
        pins[ch] = lvl;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] ets;
        int socs;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 valid", 32'(cap_valid), 0);
        check("R10 irq", 32'(cap_irq), 0);
        check("R10 soc", 32'(adc_soc), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R10: capture disabled after reset
        drive(0, 1'b1, ets);
        check("R10 disabled", 32'(cap_valid), 0);
        pins[0] = 1'b0;
        repeat (5) @(negedge clk);

        // R1 R2 R3 R6: table walk
        foreach (VEC[k]) begin
            int ch;
            ch = int'(VEC[k][7:6]);
            wr(VEC[k][7:6], {1'b1, 1'b0, 1'b1, VEC[k][5:4]});
            drive(ch, VEC[k][3], ets);
            check("R2 flag", 32'(cap_valid[ch]), 32'(VEC[k][2]));
            check("R6 irq", 32'(cap_irq[ch]), 32'(VEC[k][2]));
            if (VEC[k][2]) check("R1 stamp", 32'(cap_stamp[ch*TW +: TW]), 32'(ets));
        end

        // R5: overrun on channel 0 (pin now high)
        wr(2'd0, 5'b1_0_1_11);
        drive(0, 1'b0, ets);
        check("R5 first", 32'(cap_ovr[0]), 0);
        drive(0, 1'b1, ets);
        check("R5 ovr", 32'(cap_ovr[0]), 1);
        check("R5 newstamp", 32'(cap_stamp[0 +: TW]), 32'(ets));
        // R9: write to address 3 changes nothing
        wr(2'd3, 5'b1_0_0_00);
        check("R9 valid kept", 32'(cap_valid[0]), 1);
        check("R9 ovr kept", 32'(cap_ovr[0]), 1);
        check("R9 irq kept", 32'(cap_irq[0]), 1);
        // R4: clear
        wr(2'd0, 5'b1_0_1_11);
        check("R4 valid clr", 32'(cap_valid[0]), 0);
        check("R4 ovr clr", 32'(cap_ovr[0]), 0);

        // R6: interrupt masked while flag set
        wr(2'd1, 5'b1_0_0_11);
        drive(1, 1'b0, ets);
        check("R6 flag", 32'(cap_valid[1]), 1);
        check("R6 masked", 32'(cap_irq[1]), 0);

        // R7: conversion enable ignored on channel 0
        wr(2'd0, 5'b1_1_1_11);
        socs = 0;
        @(negedge clk); pins[0] = 1'b0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (adc_soc) socs++;
        end
        check("R7 ch0 no soc", 32'(socs), 0);

        // R7 R8: single strobe on channel 2 while pin held high
        wr(2'd2, 5'b1_1_1_01);
        socs = 0;
        @(negedge clk); pins[2] = 1'b1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (adc_soc) begin
                socs++;
                check("R8 irq with soc", 32'(cap_irq[2]), 1);
            end
        end
        check("R7 one strobe", 32'(socs), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule